// File: doc/BRIEF.md
# Data Memory Stall Controller

This block sits at the back end of a simple in-order pipeline. It sends each load or store that the pipeline hands it to a data cache port and decides whether the pipeline may move forward. When the cache answers a request with a miss, the controller enters a stall state. There is one stall state for a missed load and another for a missed store. The controller stays there until the cache raises its fill-done strobe. It then passes through a one-cycle completion state and resumes running.

A separate interrupt-block input also holds the pipeline. The `blocked` output is the OR of the two miss-stall states and that input. While `blocked` is high, no request is sent.

The controller keeps two statistics:
- A saturating count of the cycles spent in a miss stall.
- The cycle-timer value at which the most recent miss began.

An enable input moves the controller between its idle and running states. While the interrupt block is held outside a stall, the controller parks in a dedicated blocked state.

Top module: `dmem_stall_ctrl`

## Requirements
- R1: After synchronous reset the status is Idle, `req_valid` is 0, `blocked` is 0, and both `stall_cycles` and `last_stall_at` are 0.
- R2: The status output uses these encodings: Idle=0, Running=1, LoadStall=2, StoreStall=3, FillDone=4, Blocked=5. From Idle, `be_enable` high moves the status to Running. From Running with no miss, `be_enable` low moves it back to Idle.
- R3: An accepted load (`issue_store`=0) whose `rsp_hit` is 0 moves the status to LoadStall on the next clock edge.
- R4: An accepted store (`issue_store`=1) whose `rsp_hit` is 0 moves the status to StoreStall on the next clock edge.
- R5: An accepted request with `rsp_hit`=1 leaves the status at Running.
- R6: `blocked` is 1 exactly when the status is LoadStall or StoreStall, or when `intr_block` is 1.
- R7: `fill_done` in a stall state moves the status to FillDone. FillDone moves to Running on the next edge whatever the other inputs are. `fill_done` in any other state has no effect.
- R8: A sent request carries `req_cmd`=0 for a load and 1 for a store. It passes the address and size through unchanged. It copies the flags with bit 0, the instruction-fetch flag, forced to 0.
- R9: `req_valid` is high only when the status is Running, `be_enable` is 1 and `intr_block` is 0. A request is never sent while `blocked` is 1.
- R10: `stall_cycles` increments on each clock edge at which the status is a stall state. It saturates at its all-ones value.
- R11: On a miss, `last_stall_at` takes the value of the free-running cycle timer from the cycle in which the missed request was sent. The timer starts at 0 after reset and counts every cycle.
- R12: `intr_block` high in Idle or in Running (with no miss) moves the status to Blocked. When it drops, Blocked moves to Running if `be_enable` is 1, otherwise to Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| be_enable | input | 1 | Back end enabled (Idle/Running selection) |
| intr_block | input | 1 | External interrupt block |
| issue_valid | input | 1 | Pipeline offers a memory operation |
| issue_store | input | 1 | 1 = store, 0 = load |
| issue_addr | input | ADDR_W | Operation address |
| issue_size | input | SIZE_W | Access size code |
| issue_flags | input | FLAG_W | Request flags, bit 0 = instruction fetch |
| req_valid | output | 1 | Request sent to the cache this cycle |
| req_cmd | output | 1 | 0 = read, 1 = write |
| req_addr | output | ADDR_W | Request address |
| req_size | output | SIZE_W | Request size code |
| req_flags | output | FLAG_W | Request flags with the fetch bit cleared |
| rsp_hit | input | 1 | Cache hit for the request in the same cycle |
| fill_done | input | 1 | Miss completion strobe |
| blocked | output | 1 | Pipeline must hold |
| status | output | 3 | Controller status encoding |
| stall_cycles | output | CNT_W | Saturating miss-stall cycle count |
| last_stall_at | output | TIME_W | Timer value when the latest miss began |

## Verification
The main path is driven with several kinds of request:
- Load and store hits, which must leave the status at Running.
- A load miss and a store miss, which must reach different stall states, so a swapped command decode shows up.
- A request offered during a stall, which must be rejected.
- A fill strobe outside a stall, which must do nothing.

Directed cases cover the rest:
- An interrupt block raised while Running, and raised during a stall, which separate the interrupt term of `blocked` from the stall term.
- A long stall on a narrow counter, which shows saturation.
- A miss at a known cycle, which pins down the timestamp.
- A request with every flag set, which shows that only the fetch bit is cleared.

// File: rtl/dmem_stall_pkg.sv
`timescale 1ns/1ps
package dmem_stall_pkg;

    // Status encoding is visible on the status port.
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_RUN       = 3'd1,
        ST_LD_STALL  = 3'd2,
        ST_ST_STALL  = 3'd3,
        ST_FILL_DONE = 3'd4,
        ST_BLOCKED   = 3'd5
    } dstat_e;

    typedef enum logic {
        CMD_READ  = 1'b0,
        CMD_WRITE = 1'b1
    } mcmd_e;

    // Per-cycle events seen by the status machine.
    typedef struct packed {
        logic accepted;
        logic store;
        logic hit;
        logic fill;
        logic enable;
        logic intr;
    } fsm_evt_t;

    function automatic logic stat_is_stall(dstat_e s);
        return (s == ST_LD_STALL) || (s == ST_ST_STALL);
    endfunction

    function automatic mcmd_e cmd_of(logic is_store);
        return is_store ? CMD_WRITE : CMD_READ;
    endfunction

endpackage

// File: rtl/dmem_req_former.sv
`timescale 1ns/1ps
module dmem_req_former
    import dmem_stall_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 2,
    parameter int FLAG_W    = 4,
    parameter int FETCH_BIT = 0
) (
    input  logic              accept,
    input  logic              issue_valid,
    input  logic              issue_store,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic [SIZE_W-1:0] issue_size,
    input  logic [FLAG_W-1:0] issue_flags,
    output logic              req_valid,
    output mcmd_e             req_cmd,
    output logic [ADDR_W-1:0] req_addr,
    output logic [SIZE_W-1:0] req_size,
    output logic [FLAG_W-1:0] req_flags
);

    assign req_valid = issue_valid && accept;
    assign req_cmd   = cmd_of(issue_store);
    assign req_addr  = issue_addr;
    assign req_size  = issue_size;

    // The instruction-fetch marker never reaches the data port (R8).
    for (genvar b = 0; b < FLAG_W; b++) begin : g_flag
        if (b == FETCH_BIT) begin : g_clr
            assign req_flags[b] = 1'b0;
        end else begin : g_pass
            assign req_flags[b] = issue_flags[b];
        end
    end

endmodule

// File: rtl/dmem_status_fsm.sv
`timescale 1ns/1ps
module dmem_status_fsm
    import dmem_stall_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  fsm_evt_t evt,
    output dstat_e   state_q,
    output logic     miss_start
);

    dstat_e state_d;

    assign miss_start = evt.accepted && !evt.hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (evt.intr)        state_d = ST_BLOCKED;
                else if (evt.enable) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (miss_start)      state_d = evt.store ? ST_ST_STALL : ST_LD_STALL;
                else if (evt.intr)   state_d = ST_BLOCKED;
                else if (!evt.enable) state_d = ST_IDLE;
            end
            ST_LD_STALL, ST_ST_STALL: begin
                if (evt.fill)        state_d = ST_FILL_DONE;
            end
            ST_FILL_DONE: state_d = ST_RUN;
            ST_BLOCKED: begin
                if (!evt.intr)       state_d = evt.enable ? ST_RUN : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    p_load_miss_r3: assert property (@(posedge clk) disable iff (rst)
        (evt.accepted && !evt.store && !evt.hit) |=> state_q == ST_LD_STALL);

    p_store_miss_r4: assert property (@(posedge clk) disable iff (rst)
        (evt.accepted && evt.store && !evt.hit) |=> state_q == ST_ST_STALL);

    p_hit_keeps_r5: assert property (@(posedge clk) disable iff (rst)
        (evt.accepted && evt.hit) |=> state_q == ST_RUN);

    p_fill_done_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FILL_DONE) |=> state_q == ST_RUN);

    p_stall_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (stat_is_stall(state_q) && !evt.fill) |=> $stable(state_q));

endmodule

// File: rtl/dmem_stall_stats.sv
`timescale 1ns/1ps
module dmem_stall_stats #(
    parameter int CNT_W  = 16,
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_stall,
    input  logic              miss_start,
    output logic [CNT_W-1:0]  stall_cycles,
    output logic [TIME_W-1:0] last_stall_at
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [TIME_W-1:0] timer_q;

    always_ff @(posedge clk) begin
        if (rst) timer_q <= '0;
        else     timer_q <= timer_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                                   stall_cycles <= '0;
        else if (in_stall && stall_cycles != CNT_MAX) stall_cycles <= stall_cycles + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)             last_stall_at <= '0;
        else if (miss_start) last_stall_at <= timer_q;
    end

    p_sat_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (stall_cycles == CNT_MAX) |=> stall_cycles == CNT_MAX);

    p_count_step_r10: assert property (@(posedge clk) disable iff (rst)
        (in_stall && stall_cycles != CNT_MAX) |=> stall_cycles == $past(stall_cycles) + 1'b1);

    p_stamp_r11: assert property (@(posedge clk) disable iff (rst)
        miss_start |=> last_stall_at == $past(timer_q));

endmodule

// File: rtl/dmem_stall_ctrl.sv
`timescale 1ns/1ps
module dmem_stall_ctrl
    import dmem_stall_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 2,
    parameter int FLAG_W    = 4,
    parameter int FETCH_BIT = 0,
    parameter int CNT_W     = 16,
    parameter int TIME_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              be_enable,
    input  logic              intr_block,
    input  logic              issue_valid,
    input  logic              issue_store,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic [SIZE_W-1:0] issue_size,
    input  logic [FLAG_W-1:0] issue_flags,
    output logic              req_valid,
    output logic              req_cmd,
    output logic [ADDR_W-1:0] req_addr,
    output logic [SIZE_W-1:0] req_size,
    output logic [FLAG_W-1:0] req_flags,
    input  logic              rsp_hit,
    input  logic              fill_done,
    output logic              blocked,
    output logic [2:0]        status,
    output logic [CNT_W-1:0]  stall_cycles,
    output logic [TIME_W-1:0] last_stall_at
);

    dstat_e   state_q;
    fsm_evt_t evt;
    mcmd_e    cmd_w;
    logic     accept;
    logic     in_stall;
    logic     miss_start;

    assign in_stall = stat_is_stall(state_q);
    assign blocked  = in_stall || intr_block;
    assign accept   = (state_q == ST_RUN) && be_enable && !intr_block;

    assign evt = '{accepted: req_valid, store: issue_store, hit: rsp_hit,
                   fill: fill_done, enable: be_enable, intr: intr_block};

    dmem_req_former #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .FLAG_W(FLAG_W), .FETCH_BIT(FETCH_BIT)
    ) u_req (
        .accept(accept), .issue_valid(issue_valid), .issue_store(issue_store),
        .issue_addr(issue_addr), .issue_size(issue_size), .issue_flags(issue_flags),
        .req_valid(req_valid), .req_cmd(cmd_w), .req_addr(req_addr),
        .req_size(req_size), .req_flags(req_flags)
    );

    dmem_status_fsm u_fsm (
        .clk(clk), .rst(rst), .evt(evt), .state_q(state_q), .miss_start(miss_start)
    );

    dmem_stall_stats #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_stats (
        .clk(clk), .rst(rst), .in_stall(in_stall), .miss_start(miss_start),
        .stall_cycles(stall_cycles), .last_stall_at(last_stall_at)
    );

    assign req_cmd = cmd_w;
    assign status  = state_q;

    p_no_req_blocked_r9: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !blocked);

    p_stall_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        (status == 3'd2 || status == 3'd3) |-> blocked);

    p_fetch_clear_r8: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !req_flags[FETCH_BIT]);

    p_intr_park_r12: assert property (@(posedge clk) disable iff (rst)
        (intr_block && (status == 3'd0 || (status == 3'd1 && !req_valid))) |=> status == 3'd5);

endmodule

// File: tb/test_dmem_stall_ctrl.sv
`timescale 1ns/1ps
module test_dmem_stall_ctrl;

    localparam int ADDR_W = 32, SIZE_W = 2, FLAG_W = 4, CNT_W = 4, TIME_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic be_enable = 0, intr_block = 0, issue_valid = 0, issue_store = 0;
    logic [ADDR_W-1:0] issue_addr = '0;
    logic [SIZE_W-1:0] issue_size = '0;
    logic [FLAG_W-1:0] issue_flags = '0;
    logic rsp_hit = 0, fill_done = 0;
    logic req_valid, req_cmd, blocked;
    logic [ADDR_W-1:0] req_addr;
    logic [SIZE_W-1:0] req_size;
    logic [FLAG_W-1:0] req_flags;
    logic [2:0] status;
    logic [CNT_W-1:0] stall_cycles;
    logic [TIME_W-1:0] last_stall_at;

    int checks = 0;
    int errors = 0;
    int tb_cyc = 0;

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) if (!rst) tb_cyc <= tb_cyc + 1;

    dmem_stall_ctrl #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .FLAG_W(FLAG_W),
                      .FETCH_BIT(0), .CNT_W(CNT_W), .TIME_W(TIME_W)) i_dmem_stall_ctrl (
        .clk(clk), .rst(rst), .be_enable(be_enable), .intr_block(intr_block),
        .issue_valid(issue_valid), .issue_store(issue_store), .issue_addr(issue_addr),
        .issue_size(issue_size), .issue_flags(issue_flags), .req_valid(req_valid),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_size(req_size), .req_flags(req_flags),
        .rsp_hit(rsp_hit), .fill_done(fill_done), .blocked(blocked), .status(status),
        .stall_cycles(stall_cycles), .last_stall_at(last_stall_at)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // {en, ib, valid, store, hit, fill, exp_req_valid, exp_cmd, exp_status[2:0], exp_blocked, 0}
    localparam int NV = 16;
    localparam logic [12:0] VEC [NV] = '{
        13'b0_0_0_0_0_0_0_0_000_0_0,  // stay Idle (R2)
        13'b1_0_0_0_0_0_0_0_001_0_0,  // enable -> Running (R2)
        13'b1_0_1_0_1_0_1_0_001_0_0,  // load hit (R5)
        13'b1_0_1_1_1_0_1_1_001_0_0,  // store hit (R5)
        13'b1_0_1_0_0_0_1_0_010_1_0,  // load miss (R3)
        13'b1_0_1_1_0_0_0_0_010_1_0,  // offer during stall rejected (R9)
        13'b1_0_0_0_0_1_0_0_100_0_0,  // fill -> FillDone (R7)
        13'b1_0_0_0_0_0_0_0_001_0_0,  // FillDone -> Running (R7)
        13'b1_0_1_1_0_0_1_1_011_1_0,  // store miss (R4)
        13'b1_0_0_0_0_0_0_0_011_1_0,  // still stalled (R6)
        13'b1_0_0_0_0_1_0_0_100_0_0,  // fill (R7)
        13'b0_0_0_0_0_0_0_0_001_0_0,  // FillDone -> Running despite enable low (R7)
        13'b0_0_0_0_0_0_0_0_000_0_0,  // Running -> Idle (R2)
        13'b1_1_1_0_1_0_0_0_101_1_0,  // interrupt in Idle -> Blocked (R12)
        13'b1_0_0_0_0_0_0_0_001_0_0,  // release -> Running (R12)
        13'b1_0_0_0_0_1_0_0_001_0_0   // stray fill ignored (R7)
    };

    task automatic idle_inputs();
        issue_valid = 0; issue_store = 0; rsp_hit = 0; fill_done = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int stamp;
        issue_valid = 1; be_enable = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0; issue_valid = 0; be_enable = 0;
        #1;
        // R1 reset state
        check("R1 status", status, 3'd0);
        check("R1 req_valid", req_valid, 0);
        check("R1 blocked", blocked, 0);
        check("R1 stall_cycles", stall_cycles, 0);
        check("R1 last_stall_at", last_stall_at, 0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            be_enable   = VEC[i][12];
            intr_block  = VEC[i][11];
            issue_valid = VEC[i][10];
            issue_store = VEC[i][9];
            rsp_hit     = VEC[i][8];
            fill_done   = VEC[i][7];
            #1;
            check($sformatf("R9 req_valid row %0d", i), req_valid, VEC[i][6]);
            if (VEC[i][6]) check($sformatf("R8 cmd row %0d", i), req_cmd, VEC[i][5]);
            @(posedge clk); #1;
            check($sformatf("R2 status row %0d", i), status, VEC[i][4:2]);
            check($sformatf("R6 blocked row %0d", i), blocked, VEC[i][1]);
        end
        check("R10 stall count after table", stall_cycles, 4);

        // R8 request fields
        @(negedge clk);
        be_enable = 1; intr_block = 0; fill_done = 0;
        issue_valid = 1; issue_store = 1; rsp_hit = 1;
        issue_addr = 32'h0000_1234; issue_size = 2'd2; issue_flags = 4'b1011;
        #1;
        check("R8 req_valid", req_valid, 1);
        check("R8 req_cmd write", req_cmd, 1);
        check("R8 req_addr", req_addr, 32'h0000_1234);
        check("R8 req_size", req_size, 2);
        check("R8 req_flags fetch cleared", req_flags, 4'b1010);
        @(posedge clk);

        // R9 and R12: interrupt while Running
        @(negedge clk);
        intr_block = 1; issue_valid = 1; issue_store = 0; rsp_hit = 1;
        #1;
        check("R9 no req under interrupt", req_valid, 0);
        check("R6 blocked from interrupt", blocked, 1);
        @(posedge clk); #1;
        check("R12 Running -> Blocked", status, 3'd5);
        @(negedge clk);
        intr_block = 0; idle_inputs();
        @(posedge clk); #1;
        check("R12 Blocked -> Running", status, 3'd1);

        // R11 miss timestamp
        @(negedge clk);
        issue_valid = 1; issue_store = 0; rsp_hit = 0;
        stamp = tb_cyc;
        @(posedge clk); #1;
        check("R3 load miss", status, 3'd2);
        check("R11 last_stall_at", last_stall_at, stamp[TIME_W-1:0]);

        // R10 saturation, R6 interrupt during stall
        @(negedge clk);
        idle_inputs(); intr_block = 1;
        repeat (20) @(posedge clk);
        #1;
        check("R10 saturated", stall_cycles, 4'hF);
        check("R6 blocked in stall with interrupt", blocked, 1);
        check("R7 stall holds without fill", status, 3'd2);

        // R7 fill while interrupt held
        @(negedge clk);
        fill_done = 1;
        @(posedge clk); #1;
        check("R7 fill -> FillDone", status, 3'd4);
        check("R6 blocked from interrupt in FillDone", blocked, 1);
        @(negedge clk);
        fill_done = 0;
        @(posedge clk); #1;
        check("R7 FillDone -> Running", status, 3'd1);
        check("R10 count stays saturated", stall_cycles, 4'hF);
        @(posedge clk); #1;
        check("R12 Running -> Blocked under interrupt", status, 3'd5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule